// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides when a processor core enters an exception handler and computes everything the entry needs. Three kinds of event are handled: an interrupt request (a level), and prefetch-abort and data-abort requests (single-cycle pulses that are remembered until served). For the chosen event it forms the replacement status word, hands back the old status word for the saved-status register, works out the return (link) address from the program counter, and gives the handler address to the prefetch unit. A single-cycle entry strobe tells the register-banking logic to switch mode.

The sequencer also owns the core's sleep and fault states. A halt request parks the core until an interrupt line goes high. On wake-up the interrupt is taken only if the wake-time master enable is set. A prefetch abort that arrives while the vector page is not executable would loop for ever, so the sequencer freezes in a stopped state until reset. The vector page sits high (top 16 address bits all ones) or low (address zero), chosen by a parameter.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero: no entry, kind 0, zero data, neither halted nor stopped.
- R2: An interrupt request is ignored while status bit 7 is set: no entry is issued for it.
- R3: On interrupt entry the new status keeps every bit above bit 7 and has 0xD2 in bits 7..0; the saved status equals the status input sampled at the request.
- R4: On interrupt entry the link is the program counter plus 2 when status bit 5 (compressed mode) is set, else the program counter; the jump address is the vector base plus 0x18.
- R5: On either abort entry the new status is the old status with the bits of mask 0xBF cleared and then 0x97 ORed in, so bit 6 and all bits above bit 7 are kept.
- R6: A prefetch abort gives a link of the program counter plus 2 in compressed mode (plus 0 otherwise) and jumps to the base plus 0x0C.
- R7: A data abort gives a link of the program counter plus 4 in compressed mode (plus 0 otherwise) and jumps to the base plus 0x10.
- R8: The vector base is 0xFFFF0000 when HIGH_VEC is 1 and 0x00000000 when HIGH_VEC is 0.
- R9: A prefetch abort selected while the vector page is not executable issues no entry and sets stopped; stopped then stays set and no entry is issued until reset, whatever the inputs.
- R10: A halt request sets halted; while halted no entry is issued until the interrupt line is high, which clears halted; in that wake cycle the interrupt is entered only if the wake enable is 1 and status bit 7 is clear.
- R11: When requests coincide the data abort wins, then the prefetch abort, then the interrupt; an abort that loses stays pending and is entered in a later cycle.
- R12: Entry outputs are registered: a request sampled at a clock edge gives a one-cycle entry strobe right after that edge, with kind 1 for interrupt, 2 for prefetch abort, 3 for data abort, and 0 with all data outputs zero when no entry is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_in | input | DATA_W | Current status word |
| pc_in | input | ADDR_W | Current program counter |
| irq_req | input | 1 | Interrupt request level |
| pabt_req | input | 1 | Prefetch-abort pulse |
| dabt_req | input | 1 | Data-abort pulse |
| halt_req | input | 1 | Halt pulse |
| wake_irq_en | input | 1 | Master interrupt enable applied on wake-up |
| vec_exec_ok | input | 1 | Vector page has execute permission |
| ent_vld | output | 1 | Entry strobe, also the mode-switch request |
| ent_kind | output | 2 | Entry kind: 0 none, 1 interrupt, 2 prefetch abort, 3 data abort |
| new_stat | output | DATA_W | Status word to install |
| saved_stat | output | DATA_W | Old status for the saved-status register |
| link_addr | output | ADDR_W | Return address for the link register |
| jump_addr | output | ADDR_W | Handler address for the prefetch unit |
| halted | output | 1 | Core is halted |
| stopped | output | 1 | Core is permanently stopped |

## Verification
A wrong pending flag shows up as an abort entry that is missing, repeated or out of order. It appears within a cycle of the request that should have been served, because the bench model compares every output on every clock. A wrong run/halt/stop state shows at once on halted or stopped, and one cycle later as an entry strobe that should not have come (or a missing one). Mask or offset faults show on new_stat, link_addr and jump_addr in the same cycle as the strobe. The low-vector copy exposes a wrong base selection.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [1:0] {
      EK_NONE = 2'd0,
      EK_IRQ  = 2'd1,
      EK_PABT = 2'd2,
      EK_DABT = 2'd3
   } exc_kind_e;

   typedef enum logic [1:0] {
      SQ_RUN  = 2'd0,
      SQ_HALT = 2'd1,
      SQ_STOP = 2'd2
   } seq_state_e;

   // low-byte status rewrite per kind: cleared bits, then set bits
   localparam logic [7:0] IRQ_CLR = 8'hFF;
   localparam logic [7:0] IRQ_SET = 8'hD2;
   localparam logic [7:0] ABT_CLR = 8'hBF;
   localparam logic [7:0] ABT_SET = 8'h97;

   // vector offsets from the base
   localparam logic [7:0] VEC_IRQ  = 8'h18;
   localparam logic [7:0] VEC_PABT = 8'h0C;
   localparam logic [7:0] VEC_DABT = 8'h10;

   // link increments applied only in compressed mode
   localparam logic [3:0] LNK_IRQ  = 4'd2;
   localparam logic [3:0] LNK_PABT = 4'd2;
   localparam logic [3:0] LNK_DABT = 4'd4;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      allow,
   input  logic      irq_ok,
   input  logic      dabt_req,
   input  logic      pabt_req,
   output exc_kind_e sel
);

   logic pend_d;
   logic pend_p;
   logic want_d;
   logic want_p;

   assign want_d = pend_d | dabt_req;
   assign want_p = pend_p | pabt_req;

   // fixed priority: data abort, prefetch abort, interrupt
   always_comb begin
      sel = EK_NONE;
      if (allow) begin
         if (want_d)
            sel = EK_DABT;
         else if (want_p)
            sel = EK_PABT;
         else if (irq_ok)
            sel = EK_IRQ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_d <= 1'b0;
         pend_p <= 1'b0;
      end else begin
         pend_d <= want_d & (sel != EK_DABT);
         pend_p <= want_p & (sel != EK_PABT);
      end
   end

endmodule

// File: rtl/exc_frame.sv
module exc_frame
   import exc_seq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int CBIT     = 5,
   parameter bit HIGH_VEC = 1'b1
)(
   input  exc_kind_e          kind,
   input  logic [DATA_W-1:0]  stat,
   input  logic [ADDR_W-1:0]  pc,
   output logic [DATA_W-1:0]  nstat,
   output logic [ADDR_W-1:0]  link,
   output logic [ADDR_W-1:0]  jump
);

   localparam logic [ADDR_W-1:0] BASE_HI = {ADDR_W{1'b1}} << 16;

   logic [ADDR_W-1:0] base;
   logic [7:0]        clr8;
   logic [7:0]        set8;
   logic [7:0]        vec8;
   logic [3:0]        lnk4;

   generate
      if (HIGH_VEC) begin : g_base_hi
         assign base = BASE_HI;
      end else begin : g_base_lo
         assign base = '0;
      end
   endgenerate

   always_comb begin
      clr8 = 8'h00;
      set8 = 8'h00;
      vec8 = 8'h00;
      lnk4 = 4'd0;
      case (kind)
         EK_IRQ: begin
            clr8 = IRQ_CLR;
            set8 = IRQ_SET;
            vec8 = VEC_IRQ;
            lnk4 = LNK_IRQ;
         end
         EK_PABT: begin
            clr8 = ABT_CLR;
            set8 = ABT_SET;
            vec8 = VEC_PABT;
            lnk4 = LNK_PABT;
         end
         EK_DABT: begin
            clr8 = ABT_CLR;
            set8 = ABT_SET;
            vec8 = VEC_DABT;
            lnk4 = LNK_DABT;
         end
         default: ;
      endcase
   end

   assign nstat = (stat & ~DATA_W'(clr8)) | DATA_W'(set8);
   assign link  = pc + (stat[CBIT] ? ADDR_W'(lnk4) : '0);
   assign jump  = base + ADDR_W'(vec8);

endmodule

// File: rtl/exc_ctl.sv
module exc_ctl
   import exc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_req,
   input  logic       irq_req,
   input  logic       wake_irq_en,
   input  logic       sel_pabt,
   input  logic       vec_exec_ok,
   output logic       allow,
   output logic       irq_gate,
   output logic       stop_now,
   output seq_state_e st
);

   logic running;
   logic waking;
   seq_state_e st_nx;

   assign running  = (st == SQ_RUN);
   assign waking   = (st == SQ_HALT) & irq_req;
   assign allow    = running | waking;
   assign irq_gate = running | (waking & wake_irq_en);
   assign stop_now = allow & sel_pabt & ~vec_exec_ok;

   always_comb begin
      st_nx = st;
      if (stop_now)
         st_nx = SQ_STOP;
      else if (running & halt_req)
         st_nx = SQ_HALT;
      else if (waking)
         st_nx = SQ_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= SQ_RUN;
      else
         st <= st_nx;
   end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int CBIT     = 5,
   parameter int IBIT     = 7,
   parameter bit HIGH_VEC = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] stat_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              irq_req,
   input  logic              pabt_req,
   input  logic              dabt_req,
   input  logic              halt_req,
   input  logic              wake_irq_en,
   input  logic              vec_exec_ok,
   output logic              ent_vld,
   output logic [1:0]        ent_kind,
   output logic [DATA_W-1:0] new_stat,
   output logic [DATA_W-1:0] saved_stat,
   output logic [ADDR_W-1:0] link_addr,
   output logic [ADDR_W-1:0] jump_addr,
   output logic              halted,
   output logic              stopped
);

   generate
      if (DATA_W < 16) begin : g_bad_data_w
         $error("exc_entry_seq: DATA_W must be at least 16");
      end
      if (ADDR_W < 17) begin : g_bad_addr_w
         $error("exc_entry_seq: ADDR_W must be at least 17");
      end
      if (CBIT >= 8 || IBIT >= 8) begin : g_bad_bits
         $error("exc_entry_seq: mode bits must lie in the low byte");
      end
   endgenerate

   exc_kind_e         sel;
   seq_state_e        st;
   logic              allow;
   logic              irq_gate;
   logic              irq_ok;
   logic              stop_now;
   logic              issue;
   logic [DATA_W-1:0] fr_nstat;
   logic [ADDR_W-1:0] fr_link;
   logic [ADDR_W-1:0] fr_jump;

   assign irq_ok = irq_req & ~stat_in[IBIT] & irq_gate;
   assign issue  = (sel != EK_NONE) & ~stop_now;

   exc_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_req    (halt_req),
      .irq_req     (irq_req),
      .wake_irq_en (wake_irq_en),
      .sel_pabt    (sel == EK_PABT),
      .vec_exec_ok (vec_exec_ok),
      .allow       (allow),
      .irq_gate    (irq_gate),
      .stop_now    (stop_now),
      .st          (st)
   );

   exc_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .allow    (allow),
      .irq_ok   (irq_ok),
      .dabt_req (dabt_req),
      .pabt_req (pabt_req),
      .sel      (sel)
   );

   exc_frame #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .CBIT     (CBIT),
      .HIGH_VEC (HIGH_VEC)
   ) u_frame (
      .kind  (sel),
      .stat  (stat_in),
      .pc    (pc_in),
      .nstat (fr_nstat),
      .link  (fr_link),
      .jump  (fr_jump)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld    <= 1'b0;
         ent_kind   <= 2'd0;
         new_stat   <= '0;
         saved_stat <= '0;
         link_addr  <= '0;
         jump_addr  <= '0;
      end else begin
         ent_vld    <= issue;
         ent_kind   <= issue ? sel : EK_NONE;
         new_stat   <= issue ? fr_nstat : '0;
         saved_stat <= issue ? stat_in : '0;
         link_addr  <= issue ? fr_link : '0;
         jump_addr  <= issue ? fr_jump : '0;
      end
   end

   assign halted  = (st == SQ_HALT);
   assign stopped = (st == SQ_STOP);

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IBIT   = 7
)(
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] stat_in,
   input logic              irq_req,
   input logic              pabt_req,
   input logic              dabt_req,
   input logic              ent_vld,
   input logic [1:0]        ent_kind,
   input logic [DATA_W-1:0] new_stat,
   input logic [DATA_W-1:0] saved_stat,
   input logic [ADDR_W-1:0] jump_addr,
   input logic              halted,
   input logic              stopped
);

   p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld && ent_kind == 2'd1) |-> !$past(stat_in[IBIT]));

   p_irq_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld && ent_kind == 2'd1) |->
         (new_stat[7:0] == 8'hD2 && new_stat[DATA_W-1:8] == saved_stat[DATA_W-1:8]));

   p_irq_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld && ent_kind == 2'd1) |-> (jump_addr[7:0] == 8'h18));

   p_abt_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld && ent_kind[1]) |->
         ((new_stat[7:0] & 8'hBF) == 8'h97 && new_stat[6] == saved_stat[6]));

   p_stop_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> (stopped && !ent_vld));

   p_halt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !irq_req) |=> (halted && !ent_vld));

   p_state_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted && stopped));

   p_irq_loses_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld && ent_kind == 2'd1) |-> (!$past(dabt_req) && !$past(pabt_req)));

   p_strobe_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ent_vld == (ent_kind != 2'd0));

endmodule

bind exc_entry_seq exc_seq_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .IBIT   (IBIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stat_in    (stat_in),
   .irq_req    (irq_req),
   .pabt_req   (pabt_req),
   .dabt_req   (dabt_req),
   .ent_vld    (ent_vld),
   .ent_kind   (ent_kind),
   .new_stat   (new_stat),
   .saved_stat (saved_stat),
   .jump_addr  (jump_addr),
   .halted     (halted),
   .stopped    (stopped)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] stat_in = 32'h0;
   logic [31:0] pc_in = 32'h0;
   logic        irq_req = 1'b0;
   logic        pabt_req = 1'b0;
   logic        dabt_req = 1'b0;
   logic        halt_req = 1'b0;
   logic        wake_irq_en = 1'b0;
   logic        vec_exec_ok = 1'b1;

   logic        ent_vld, halted, stopped;
   logic [1:0]  ent_kind;
   logic [31:0] new_stat, saved_stat, link_addr, jump_addr;

   logic        lo_vld, lo_halted, lo_stopped;
   logic [1:0]  lo_kind;
   logic [31:0] lo_nstat, lo_saved, lo_link, lo_jump;

   always #2 clk = ~clk;

   exc_entry_seq i_exc_entry_seq (
      .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .pc_in(pc_in),
      .irq_req(irq_req), .pabt_req(pabt_req), .dabt_req(dabt_req),
      .halt_req(halt_req), .wake_irq_en(wake_irq_en), .vec_exec_ok(vec_exec_ok),
      .ent_vld(ent_vld), .ent_kind(ent_kind), .new_stat(new_stat),
      .saved_stat(saved_stat), .link_addr(link_addr), .jump_addr(jump_addr),
      .halted(halted), .stopped(stopped)
   );

   exc_entry_seq #(.HIGH_VEC(1'b0)) i_exc_entry_seq_low (
      .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .pc_in(pc_in),
      .irq_req(irq_req), .pabt_req(pabt_req), .dabt_req(dabt_req),
      .halt_req(halt_req), .wake_irq_en(wake_irq_en), .vec_exec_ok(vec_exec_ok),
      .ent_vld(lo_vld), .ent_kind(lo_kind), .new_stat(lo_nstat),
      .saved_stat(lo_saved), .link_addr(lo_link), .jump_addr(lo_jump),
      .halted(lo_halted), .stopped(lo_stopped)
   );

   int    checks = 0;
   int    errors = 0;
   string phase = "R1";

   // behavioural reference model
   int          m_st = 0;      // 0 running, 1 halted, 2 stopped
   bit          m_pd = 0, m_pp = 0;
   bit          e_vld = 0;
   int          e_kind = 0;
   logic [31:0] e_ns = 0, e_sv = 0, e_lk = 0, e_jp = 0, e_jlo = 0;
   bit          m_run, m_wake, m_irq_can, m_stop;
   int          k;
   int          m_off;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_pd = 0; m_pp = 0;
         e_vld = 0; e_kind = 0; e_ns = 0; e_sv = 0; e_lk = 0; e_jp = 0; e_jlo = 0;
      end else begin
         m_run     = (m_st == 0);
         m_wake    = (m_st == 1) && irq_req;
         m_irq_can = irq_req && !stat_in[7] && (m_run || (m_wake && wake_irq_en));
         k = 0;
         if (m_run || m_wake) begin
            if (m_pd || dabt_req) k = 3;
            else if (m_pp || pabt_req) k = 2;
            else if (m_irq_can) k = 1;
         end
         m_pd = (m_pd || dabt_req) && (k != 3);
         m_pp = (m_pp || pabt_req) && (k != 2);
         m_stop = (k == 2) && !vec_exec_ok;
         e_vld = 0; e_kind = 0; e_ns = 0; e_sv = 0; e_lk = 0; e_jp = 0; e_jlo = 0;
         if (k != 0 && !m_stop) begin
            e_vld = 1;
            e_kind = k;
            e_sv = stat_in;
            if (k == 1) begin
               e_ns  = {stat_in[31:8], 8'hD2};
               m_off = stat_in[5] ? 2 : 0;
               e_jlo = 32'h18;
            end else begin
               e_ns  = (stat_in & ~32'hBF) | 32'h97;
               m_off = stat_in[5] ? ((k == 3) ? 4 : 2) : 0;
               e_jlo = (k == 3) ? 32'h10 : 32'h0C;
            end
            e_lk = pc_in + m_off;
            e_jp = 32'hFFFF0000 + e_jlo;
         end
         if (m_stop) m_st = 2;
         else if (m_run && halt_req) m_st = 1;
         else if (m_wake) m_st = 0;
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      chk({phase, "/R12"}, "ent_vld", 32'(ent_vld), 32'(e_vld));
      chk({phase, "/R12"}, "ent_kind", 32'(ent_kind), 32'(e_kind));
      chk({phase, "/R3/R5"}, "new_stat", new_stat, e_ns);
      chk({phase, "/R3"}, "saved_stat", saved_stat, e_sv);
      chk({phase, "/R4/R6/R7"}, "link_addr", link_addr, e_lk);
      chk({phase, "/R4/R6/R7"}, "jump_addr", jump_addr, e_jp);
      chk({phase, "/R10"}, "halted", 32'(halted), 32'(m_st == 1));
      chk({phase, "/R9"}, "stopped", 32'(stopped), 32'(m_st == 2));
      chk("R8", "low jump_addr", lo_jump, e_jlo);
      chk("R8", "low ent_vld", 32'(lo_vld), 32'(e_vld));
   end

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic clear_reqs();
      irq_req = 0; pabt_req = 0; dabt_req = 0; halt_req = 0;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      phase = "R1";
      tick(3);
      rst_n = 1;
      tick(2);

      // R2: masked interrupt is ignored
      phase = "R2";
      stat_in = 32'h0000_00D3; pc_in = 32'h0200_0000; irq_req = 1;
      tick(3);
      clear_reqs(); tick(1);

      // R3/R4: interrupt in normal and compressed mode
      phase = "R3";
      stat_in = 32'h1234_5613; pc_in = 32'h0200_0100; irq_req = 1;
      tick(1); clear_reqs(); tick(2);
      phase = "R4";
      stat_in = 32'hA000_003F; pc_in = 32'h0300_0042; irq_req = 1;
      tick(1); clear_reqs(); tick(2);

      // R5/R6: prefetch aborts, bit 6 kept
      phase = "R6";
      stat_in = 32'h4000_0050; pc_in = 32'h0200_1000; pabt_req = 1;
      tick(1); clear_reqs(); tick(1);
      stat_in = 32'h0000_00F0; pc_in = 32'h0200_2002; pabt_req = 1;
      tick(1); clear_reqs(); tick(1);

      // R5/R7: data aborts
      phase = "R7";
      stat_in = 32'h8000_0010; pc_in = 32'h0200_3000; dabt_req = 1;
      tick(1); clear_reqs(); tick(1);
      stat_in = 32'h0000_0070; pc_in = 32'h0200_4004; dabt_req = 1;
      tick(1); clear_reqs(); tick(1);

      // R11: all three at once, interrupt held
      phase = "R11";
      stat_in = 32'h0000_0010; pc_in = 32'h0200_5000;
      dabt_req = 1; pabt_req = 1; irq_req = 1;
      tick(1);
      dabt_req = 0; pabt_req = 0;
      tick(2);
      clear_reqs(); tick(2);

      // R10: halt, abort held pending, wake without enable
      phase = "R10";
      halt_req = 1; tick(1); halt_req = 0; tick(2);
      pabt_req = 1; tick(1); pabt_req = 0; tick(2);
      wake_irq_en = 0; irq_req = 1; tick(1); irq_req = 0; tick(2);
      // halt, wake with enable -> interrupt taken
      halt_req = 1; tick(1); halt_req = 0; tick(2);
      wake_irq_en = 1; pc_in = 32'h0200_6000; irq_req = 1; tick(1); irq_req = 0; tick(2);
      // halt, wake with status mask set -> no entry
      halt_req = 1; tick(1); halt_req = 0; tick(1);
      stat_in = 32'h0000_0090; irq_req = 1; tick(1); irq_req = 0; tick(2);

      // R9: prefetch abort with non-executable vector page
      phase = "R9";
      stat_in = 32'h0000_0010; vec_exec_ok = 0; pabt_req = 1;
      tick(1); clear_reqs(); vec_exec_ok = 1; tick(1);
      irq_req = 1; dabt_req = 1; halt_req = 1; tick(3);
      clear_reqs(); pabt_req = 1; tick(1); clear_reqs(); tick(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule